// File: doc/BRIEF.md
# Dual-Strobe PCM Serial Port

This block is the serial side of a voice converter's sample path. One shared shift clock carries two independent framed channels. A transmit strobe starts each outgoing word. A receive strobe starts each incoming word. On transmit, the port takes a parallel sample through a valid/ready input, formats it, and shifts it out MSB first on a data pin that has a separate output-enable. On receive, it assembles serial bits into a word and places the word in a holding latch. The latch is offered on a valid/ready output.

The shift clock, the strobes and the receive data are sampled by a faster system clock, and the port reacts to the edges it sees there. Each frame carries either a 16-bit linear word or an 8-bit companded byte, chosen by a format pin. Short or long framing is worked out from how many falling shift-clock edges see the strobe high. Back-pressure works as follows. The transmit input accepts one word into a single staging register. `tx_ready` stays low until a transmit frame starts and takes that word. If no new word arrives, the next frame resends the staged word. The receive output holds `rx_valid` and `rx_word` until `rx_ready` is seen. A newer word that completes before then overwrites the latch.

Top module: `pcm_port`

## Requirements
- R1: While reset is active and right after it, `txd_oe`, `txd`, `rx_valid` and `frame_long` are 0 and `tx_ready` is 1.
- R2: A frame starts at a falling shift-clock edge that samples the strobe high after the previous falling edge sampled it low. Transmit bits change on the following rising edges, MSB first. Receive bits are sampled on the following falling edges.
- R3: The frame length is 16 bits when `fmt_alaw` is 0 and 8 bits when it is 1. The value is captured at the frame start. An internal counter ends the word, so the strobe may drop early.
- R4: In linear format, `tx_word[15:3]` is sent followed by three 0 bits. The received word is latched as its first 13 bits in `rx_word[15:3]`, and `rx_word[2:0]` is 0.
- R5: In companded format, `tx_word[7:0]` is sent with bits 0, 2, 4 and 6 inverted (XOR 0x55). The received byte is XORed with 0x55 and placed in `rx_word[7:0]`, and `rx_word[15:8]` is 0.
- R6: In short framing (strobe high at 1 or 2 falling edges), `txd_oe` drops after the falling edge of the last bit.
- R7: In long framing (strobe high at 3 or more consecutive falling edges), the matching bit of `frame_long` (0 transmit, 1 receive) is 1. `txd_oe` then stays high, holding the last bit, until the strobe is low if that is later than the last bit.
- R8: `txd_oe` is 0 while `tx_enable` is 0. After `tx_enable` rises, it stays 0 for the first transmit frame and drives from the second frame on.
- R9: A strobe start during a word restarts that channel with a fresh word and a full bit count. The data pin is not released in between.
- R10: `tx_ready` is 1 when the staging register is empty. It drops after a handshake and returns to 1 at the next transmit frame start, which consumes the word. A frame with no new word resends the last staged word.
- R11: `rx_valid` rises when a word is latched. It holds with `rx_word` until `rx_ready` is sampled high. A word completed meanwhile replaces the latch contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the shift clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | Shared PCM shift clock |
| tx_strobe | input | 1 | Transmit frame strobe |
| rx_strobe | input | 1 | Receive frame strobe |
| rxd | input | 1 | Serial receive data |
| fmt_alaw | input | 1 | 0: 16-bit linear, 1: 8-bit companded |
| tx_enable | input | 1 | Transmit channel enable |
| tx_word | input | 16 | Parallel transmit sample |
| tx_valid | input | 1 | Transmit sample offered |
| tx_ready | output | 1 | Staging register empty |
| txd | output | 1 | Serial transmit data |
| txd_oe | output | 1 | Drive enable for `txd` (0 = high impedance) |
| rx_word | output | 16 | Latched receive word |
| rx_valid | output | 1 | Receive latch holds an unread word |
| rx_ready | input | 1 | Consumer takes the latched word |
| frame_long | output | 2 | Long framing detected: bit 0 transmit, bit 1 receive |

## Verification
The hardest conditions to reach from the ports are a strobe that outlasts the word in long framing, and a second strobe that lands while a word is still shifting. A release or reload one edge off in either case is easy to miss. The bench drives the shift clock itself, one period per task call, and sets the strobe bit by bit from a per-cycle mask. This lets it place a strobe tail two clocks past the last bit, or put a restart at the fifth bit. It records `txd` and `txd_oe` once per period just before the falling edge, so that the exact cycle of release can be compared. The two-frame enable delay is reached by raising `tx_enable` just before the first frame after reset.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int DEF_WORD_W   = 16;
  localparam int DEF_NARROW_W = 8;
  localparam int DEF_SAMPLE_W = 13;
  localparam int DEF_LONG_MIN = 3;
  localparam int NUM_CHAN     = 2;  // index 0 transmit, 1 receive

  // mask with every even-numbered bit set, for the alternate-bit inversion
  function automatic logic [63:0] even_bits(int width);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < width; i += 2) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pcm_strobe_mon.sv
module pcm_strobe_mon #(
  parameter int LONG_MIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall,
  input  logic strobe,
  output logic start,
  output logic long_mode
);
  localparam int CW = $clog2(LONG_MIN + 1);

  logic          prev_hi;
  logic [CW-1:0] wcnt;

  assign start     = fall && strobe && !prev_hi;
  assign long_mode = (wcnt == CW'(LONG_MIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_hi <= 1'b0;
      wcnt    <= '0;
    end else if (fall) begin
      prev_hi <= strobe;
      if (start)
        wcnt <= CW'(1);
      else if (strobe && prev_hi && wcnt != CW'(LONG_MIN))
        wcnt <= wcnt + CW'(1);
    end
  end
endmodule

// File: rtl/pcm_tx.sv
module pcm_tx import pcm_port_pkg::*; #(
  parameter int WORD_W   = DEF_WORD_W,
  parameter int NARROW_W = DEF_NARROW_W,
  parameter int SAMPLE_W = DEF_SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              fall,
  input  logic              start,
  input  logic              long_mode,
  input  logic              strobe,
  input  logic              alaw,
  input  logic              enable,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              txd,
  output logic              txd_oe
);
  localparam int BW = $clog2(WORD_W + 1);
  localparam logic [NARROW_W-1:0] AMI = NARROW_W'(even_bits(NARROW_W));

  logic [WORD_W-1:0] stage, shreg, framed;
  logic              stage_full, busy, tail, drive_ok;
  logic [BW-1:0]     bits_left;
  logic [1:0]        fcnt;

  assign in_ready = !stage_full;

  always_comb begin
    if (alaw) framed = {stage[NARROW_W-1:0] ^ AMI, {(WORD_W-NARROW_W){1'b0}}};
    else      framed = {stage[WORD_W-1 -: SAMPLE_W], {(WORD_W-SAMPLE_W){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage      <= '0;
      stage_full <= 1'b0;
    end else if (in_valid && in_ready) begin
      stage      <= in_word;
      stage_full <= 1'b1;
    end else if (start) begin
      stage_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0; bits_left <= '0; busy <= 1'b0; tail <= 1'b0;
      fcnt <= '0; drive_ok <= 1'b0; txd <= 1'b0; txd_oe <= 1'b0;
    end else if (!enable) begin
      busy <= 1'b0; tail <= 1'b0; fcnt <= '0; drive_ok <= 1'b0;
      txd <= 1'b0; txd_oe <= 1'b0;
    end else if (start) begin
      shreg     <= framed;
      bits_left <= alaw ? BW'(NARROW_W) : BW'(WORD_W);
      busy      <= 1'b1;
      tail      <= 1'b0;
      drive_ok  <= (fcnt != 2'd0);
      if (fcnt != 2'd2) fcnt <= fcnt + 2'd1;
    end else begin
      if (rise && busy && bits_left != '0) begin
        txd       <= shreg[WORD_W-1];
        shreg     <= {shreg[WORD_W-2:0], 1'b0};
        bits_left <= bits_left - BW'(1);
        txd_oe    <= drive_ok;
      end
      if (fall && busy && bits_left == '0) begin
        busy <= 1'b0;
        if (long_mode && strobe) tail <= 1'b1;
        else begin txd_oe <= 1'b0; txd <= 1'b0; end
      end
      if (tail && !strobe) begin
        tail <= 1'b0; txd_oe <= 1'b0; txd <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcm_rx.sv
module pcm_rx import pcm_port_pkg::*; #(
  parameter int WORD_W   = DEF_WORD_W,
  parameter int NARROW_W = DEF_NARROW_W,
  parameter int SAMPLE_W = DEF_SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              start,
  input  logic              rxd,
  input  logic              alaw,
  output logic [WORD_W-1:0] out_word,
  output logic              out_valid,
  input  logic              out_ready
);
  localparam int BW = $clog2(WORD_W + 1);
  localparam logic [NARROW_W-1:0] AMI = NARROW_W'(even_bits(NARROW_W));

  logic [WORD_W-1:0] shreg, nxt, packed_w;
  logic [BW-1:0]     bits_left;
  logic              busy, alaw_q, done;

  assign nxt  = {shreg[WORD_W-2:0], rxd};
  assign done = fall && busy && !start && bits_left == BW'(1);

  always_comb begin
    if (alaw_q) packed_w = {{(WORD_W-NARROW_W){1'b0}}, nxt[NARROW_W-1:0] ^ AMI};
    else        packed_w = {nxt[WORD_W-1 -: SAMPLE_W], {(WORD_W-SAMPLE_W){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0; bits_left <= '0; busy <= 1'b0; alaw_q <= 1'b0;
    end else if (start) begin
      shreg     <= '0;
      bits_left <= alaw ? BW'(NARROW_W) : BW'(WORD_W);
      busy      <= 1'b1;
      alaw_q    <= alaw;
    end else if (fall && busy) begin
      shreg     <= nxt;
      bits_left <= bits_left - BW'(1);
      if (bits_left == BW'(1)) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_word  <= '0;
      out_valid <= 1'b0;
    end else if (done) begin
      out_word  <= packed_w;
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_port.sv
module pcm_port import pcm_port_pkg::*; #(
  parameter int WORD_W   = DEF_WORD_W,
  parameter int NARROW_W = DEF_NARROW_W,
  parameter int SAMPLE_W = DEF_SAMPLE_W,
  parameter int LONG_MIN = DEF_LONG_MIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              tx_strobe,
  input  logic              rx_strobe,
  input  logic              rxd,
  input  logic              fmt_alaw,
  input  logic              tx_enable,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd,
  output logic              txd_oe,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [1:0]        frame_long
);
  logic sclk_s, sclk_d, sclk_rise, sclk_fall;
  logic [NUM_CHAN-1:0] strobes, starts;
  logic tx_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      sclk_s <= sclk;
      sclk_d <= sclk_s;
    end
  end

  assign sclk_rise = sclk_s && !sclk_d;
  assign sclk_fall = !sclk_s && sclk_d;
  assign strobes   = {rx_strobe, tx_strobe};
  assign tx_start  = starts[0];

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_mon
    pcm_strobe_mon #(.LONG_MIN(LONG_MIN)) u_mon (
      .clk(clk), .rst_n(rst_n), .fall(sclk_fall), .strobe(strobes[g]),
      .start(starts[g]), .long_mode(frame_long[g])
    );
  end

  pcm_tx #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .SAMPLE_W(SAMPLE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .rise(sclk_rise), .fall(sclk_fall),
    .start(tx_start), .long_mode(frame_long[0]), .strobe(tx_strobe),
    .alaw(fmt_alaw), .enable(tx_enable), .in_word(tx_word),
    .in_valid(tx_valid), .in_ready(tx_ready), .txd(txd), .txd_oe(txd_oe)
  );

  pcm_rx #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .SAMPLE_W(SAMPLE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .fall(sclk_fall), .start(starts[1]),
    .rxd(rxd), .alaw(fmt_alaw), .out_word(rx_word),
    .out_valid(rx_valid), .out_ready(rx_ready)
  );
endmodule

// File: rtl/pcm_port_chk.sv
module pcm_port_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txd_oe,
  input logic              tx_enable,
  input logic              tx_ready,
  input logic              tx_start,
  input logic              sclk_rise,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [WORD_W-1:0] rx_word
);
  // R1: idle outputs while reset is held
  always @(posedge clk)
    if (!rst_n) a_r1_idle_in_reset: assert (!txd_oe && !rx_valid && tx_ready);

  // R8: no drive one cycle after enable is low
  a_r8_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |=> !txd_oe);

  // R2: the data pin starts driving only after a rising shift edge
  a_r2_drive_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txd_oe) |-> $past(sclk_rise));

  // R10: a full stage stays full until a transmit frame starts
  a_r10_stage_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !tx_start) |=> !tx_ready);

  // R11: an unread word is not dropped
  a_r11_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  // R4/R5: a latched word never has both reserved regions nonzero
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_word[WORD_W-1:8] == '0 || rx_word[2:0] == 3'b000));
endmodule

bind pcm_port pcm_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd_oe(txd_oe), .tx_enable(tx_enable),
  .tx_ready(tx_ready), .tx_start(tx_start), .sclk_rise(sclk_rise),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_word(rx_word)
);

// File: tb/sim_pcm_port.sv
module sim_pcm_port;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, sclk, tx_strobe, rx_strobe, rxd, fmt_alaw, tx_enable;
  logic [15:0] tx_word, rx_word;
  logic tx_valid, tx_ready, txd, txd_oe, rx_valid, rx_ready;
  logic [1:0] frame_long;

  pcm_port u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .tx_strobe(tx_strobe),
    .rx_strobe(rx_strobe), .rxd(rxd), .fmt_alaw(fmt_alaw),
    .tx_enable(tx_enable), .tx_word(tx_word), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .txd(txd), .txd_oe(txd_oe), .rx_word(rx_word),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .frame_long(frame_long)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic cap_txd [64];
  logic cap_oe  [64];

  // {alaw, two-period strobe, tx word, rx word}
  localparam logic [33:0] VEC [4] = '{
    {1'b0, 1'b0, 16'hA5C3, 16'h3E71},
    {1'b1, 1'b1, 16'h00D2, 16'h00B4},
    {1'b0, 1'b1, 16'h8001, 16'hFFFF},
    {1'b1, 1'b0, 16'h12FF, 16'h0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] tx_form(input logic alaw, input logic [15:0] w);
    return alaw ? {w[7:0] ^ 8'h55, 8'h00} : {w[15:3], 3'b000};
  endfunction

  function automatic logic [15:0] rx_form(input logic alaw, input logic [15:0] w);
    return alaw ? {8'h00, w[7:0] ^ 8'h55} : {w[15:3], 3'b000};
  endfunction

  // one shift period; inputs change at the rise, outputs sampled before the fall
  task automatic tick(input logic ts, input logic rs, input logic rb, output logic tb, output logic to);
    sclk = 1'b1; tx_strobe = ts; rx_strobe = rs; rxd = rb;
    repeat (4) @(negedge clk);
    tb = txd; to = txd_oe;
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_frame(input int ncyc, input logic [63:0] tmask,
                           input logic [63:0] rmask, input logic [63:0] rbits);
    for (int i = 0; i < ncyc; i++) tick(tmask[i], rmask[i], rbits[i], cap_txd[i], cap_oe[i]);
  endtask

  task automatic push(input logic [15:0] w);
    tx_word = w; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic drain();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  function automatic logic [63:0] rx_serial(input logic alaw, input logic [15:0] w);
    logic [63:0] b;
    int n;
    b = '0;
    n = alaw ? 8 : 16;
    for (int i = 1; i <= n; i++) b[i] = w[n - i];
    return b;
  endfunction

  function automatic logic [63:0] oe_bits(input int ncyc);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < ncyc; i++) m[i] = cap_oe[i];
    return m;
  endfunction

  function automatic logic [15:0] tx_bits(input int first, input int n);
    logic [15:0] v;
    v = '0;
    for (int i = 0; i < n; i++) v = {v[14:0], cap_txd[first + i]};
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic alaw, l2;
    logic [15:0] tw, rw, ftx;
    int n;
    rst_n = 1'b0; sclk = 1'b0; tx_strobe = 1'b0; rx_strobe = 1'b0; rxd = 1'b0;
    fmt_alaw = 1'b0; tx_enable = 1'b0; tx_word = '0; tx_valid = 1'b0; rx_ready = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd_oe", txd_oe, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 frame_long", frame_long, 0);

    // R8: first frame after enable is not driven
    tx_enable = 1'b1;
    push(16'h1234);
    run_frame(18, 64'h1, 64'h1, '0);
    chk("R8 first frame silent", oe_bits(18), 0);
    drain();

    // table walk: R2 R3 R4 R5 R6 R10
    for (int v = 0; v < 4; v++) begin
      alaw = VEC[v][33]; l2 = VEC[v][32]; tw = VEC[v][31:16]; rw = VEC[v][15:0];
      n = alaw ? 8 : 16;
      fmt_alaw = alaw;
      push(tw);
      chk("R10 ready low after accept", tx_ready, 0);
      run_frame(n + 2, l2 ? 64'h3 : 64'h1, l2 ? 64'h3 : 64'h1, rx_serial(alaw, rw));
      ftx = tx_form(alaw, tw);
      chk(alaw ? "R5 R3 tx bits" : "R4 R3 tx bits", tx_bits(1, n), alaw ? {8'h00, ftx[15:8]} : ftx);
      chk("R6 R2 oe window", oe_bits(n + 2), ((64'h1 << (n + 1)) - 1) & ~64'h1);
      chk(alaw ? "R5 rx word" : "R4 rx word", rx_word, rx_form(alaw, rw));
      chk("R10 ready after start", tx_ready, 1);
      chk("R7 short framing", frame_long, 0);
      drain();
      chk("R11 cleared by ready", rx_valid, 0);
    end

    // R7: long strobe outlasting an 8-bit word
    fmt_alaw = 1'b1;
    push(16'h00C6);
    run_frame(13, 64'h7FF, 64'h7FF, '0);
    ftx = tx_form(1'b1, 16'h00C6);
    chk("R7 frame_long", frame_long, 2'b11);
    chk("R7 oe held to strobe end", oe_bits(13), 64'h7FE);
    chk("R7 tx bits", tx_bits(1, 8), {8'h00, ftx[15:8]});
    chk("R7 last bit held", {cap_txd[9], cap_txd[10]}, {2{ftx[8]}});
    drain();

    // R9 restart mid-word, R10 resend of staged word
    fmt_alaw = 1'b0;
    push(16'hC35A);
    run_frame(24, 64'h21, 64'h0, '0);
    ftx = tx_form(1'b0, 16'hC35A);
    chk("R9 bits before restart", tx_bits(1, 5), {11'h0, ftx[15:11]});
    chk("R9 R10 full word after restart", tx_bits(6, 16), ftx);
    chk("R9 oe continuous", oe_bits(24), 64'h3FFFFE);

    // R11 hold and overwrite
    run_frame(18, 64'h0, 64'h1, rx_serial(1'b0, 16'h7778));
    run_frame(3, 64'h0, 64'h0, '0);
    chk("R11 held", {rx_valid, rx_word}, {1'b1, 16'h7778});
    run_frame(18, 64'h0, 64'h1, rx_serial(1'b0, 16'h1235));
    chk("R11 overwrite", {rx_valid, rx_word}, {1'b1, 16'h1230});
    drain();

    // R8: disabled channel stays quiet
    tx_enable = 1'b0;
    push(16'hFFFF);
    run_frame(18, 64'h1, 64'h0, '0);
    chk("R8 disabled silent", oe_bits(18), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule